// File: doc/BRIEF.md
# Up/Down Stack Pointer Register

This block holds an 8-bit stack pointer that sits on a shared data bus. Software, through microcode, can write it from the bus, read it back onto the bus, and step it up or down by one as values are pushed and pulled. The current value is also presented continuously on a separate output so that an address register can take it without going through the bus.

No dedicated up or down controls exist. A single stack strobe is qualified by two carry-control lines that other units of the datapath also use. With the strobe low those lines never touch the pointer. The strobe with only the down line high steps the pointer down. The strobe with only the up line high steps it up. Any other combination holds the pointer. A write on the same edge always wins over a step.

The register has no reset and powers up with an undefined value. Programs must load it before they use the stack. Stepping past either end of the 8-bit range wraps silently and raises no flag. All state changes take place on the rising clock edge.

Top module: `stkptr_updown`

## Requirements
- R1: When `wr_sel` is high at a rising edge, the pointer takes the value on `bus_in` after that edge.
- R2: With `wr_sel` low, `stk_en` high, `cc_dn` high and `cc_up` low at an edge, the pointer decreases by one.
- R3: With `wr_sel` low, `stk_en` high, `cc_up` high and `cc_dn` low at an edge, the pointer increases by one.
- R4: With `stk_en` low and `wr_sel` low, the pointer keeps its value whatever `cc_dn` and `cc_up` are.
- R5: With `stk_en` high and `cc_dn` and `cc_up` either both high or both low (and `wr_sel` low), the pointer keeps its value.
- R6: When `wr_sel` is high together with a step command, the load takes effect and the step is discarded.
- R7: Stepping up from 0xFF gives 0x00 and stepping down from 0x00 gives 0xFF, with no indication.
- R8: `bus_oe` equals `rd_sel`. While `rd_sel` is high, `bus_out` equals the pointer. While it is low, `bus_out` is all zeros.
- R9: `ptr_addr` always shows the current pointer value, and `rd_sel` alone never changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all updates on the rising edge |
| stk_en | input | 1 | Stack strobe that qualifies the carry-control lines |
| cc_dn | input | 1 | Shared carry-control line; with `stk_en` requests a step down |
| cc_up | input | 1 | Shared carry-control line; with `stk_en` requests a step up |
| wr_sel | input | 1 | Load the pointer from `bus_in` |
| rd_sel | input | 1 | Drive the pointer onto the bus |
| bus_in | input | PTR_W (8) | Data bus value for loads |
| bus_out | output | PTR_W (8) | Pointer value toward the bus; zero when not driving |
| bus_oe | output | 1 | Bus drive enable |
| ptr_addr | output | PTR_W (8) | Current pointer value for address use |

## Verification
The step assertions compare the pointer with its previous value, so they are held off until the first load has made that value defined. The bench therefore writes the pointer before any step vector. The load and bus assertions assume only that the inputs are settled at each rising edge. The bench meets this by changing every input on the falling edge and reading outputs a quarter period after the rising edge. The stimulus leaves the control lines free in every combination, including loads that coincide with steps and strobes with both or neither carry line set, because the design defines a result for each of them.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

  // Action selected for the pointer on the next clock edge.
  typedef enum logic [1:0] {
    SP_HOLD = 2'd0,
    SP_LOAD = 2'd1,
    SP_UP   = 2'd2,
    SP_DOWN = 2'd3
  } sp_op_e;

endpackage

// File: rtl/stkptr_op_decode.sv
module stkptr_op_decode
  import stkptr_pkg::*;
(
  input  logic   stk_en,
  input  logic   cc_dn,
  input  logic   cc_up,
  input  logic   wr_sel,
  output sp_op_e op
);

  logic step_dn;
  logic step_up;

  // A step needs the strobe and exactly one carry-control line.
  assign step_dn = stk_en & cc_dn & ~cc_up;
  assign step_up = stk_en & cc_up & ~cc_dn;

  always_comb begin
    if (wr_sel)       op = SP_LOAD;   // load outranks any step
    else if (step_dn) op = SP_DOWN;
    else if (step_up) op = SP_UP;
    else              op = SP_HOLD;
  end

  // Carry-control traffic for other units must never reach the pointer.
  always_comb begin
    if (!stk_en && !wr_sel)
      AST_CC_ALONE_HOLD: assert (op == SP_HOLD); // R4
  end

endmodule

// File: rtl/stkptr_count_core.sv
module stkptr_count_core
  import stkptr_pkg::*;
#(
  parameter int PTR_W     = 8,
  parameter bit TOG_CHAIN = 1'b1
) (
  input  logic             clk,
  input  sp_op_e           op,
  input  logic [PTR_W-1:0] din,
  output logic [PTR_W-1:0] q
);

  logic [PTR_W-1:0] q_inc;
  logic [PTR_W-1:0] q_dec;
  logic [PTR_W-1:0] q_nxt;

  generate
    if (TOG_CHAIN) begin : g_chain
      // Bit i toggles when every lower bit is 1 (up) or 0 (down).
      logic [PTR_W-1:0] tog_up;
      logic [PTR_W-1:0] tog_dn;
      assign tog_up[0] = 1'b1;
      assign tog_dn[0] = 1'b1;
      for (genvar i = 1; i < PTR_W; i++) begin : g_bit
        assign tog_up[i] = tog_up[i-1] &  q[i-1];
        assign tog_dn[i] = tog_dn[i-1] & ~q[i-1];
      end
      assign q_inc = q ^ tog_up;
      assign q_dec = q ^ tog_dn;
    end else begin : g_adder
      assign q_inc = q + PTR_W'(1);
      assign q_dec = q - PTR_W'(1);
    end
  endgenerate

  always_comb begin
    unique case (op)
      SP_LOAD: q_nxt = din;
      SP_UP:   q_nxt = q_inc;
      SP_DOWN: q_nxt = q_dec;
      default: q_nxt = q;
    endcase
  end

  // No reset: the pointer is undefined until the first load.
  always_ff @(posedge clk) begin
    q <= q_nxt;
  end

  // Checker state: one flag after the first edge, one after the first load.
  logic chk_live   = 1'b0;
  logic chk_loaded = 1'b0;
  always_ff @(posedge clk) begin
    chk_live <= 1'b1;
    if (op == SP_LOAD) chk_loaded <= 1'b1;
  end

  AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (!chk_live)
    (op == SP_LOAD) |=> (q == $past(din))); // R1

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!chk_loaded)
    (op == SP_DOWN) |=> (q == $past(q) - PTR_W'(1))); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!chk_loaded)
    (op == SP_UP) |=> (q == $past(q) + PTR_W'(1))); // R3

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!chk_loaded)
    (op == SP_HOLD) |=> $stable(q)); // R5

  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!chk_loaded)
    (op == SP_UP && q == {PTR_W{1'b1}}) |=> (q == '0)); // R7

  AST_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!chk_loaded)
    (op == SP_DOWN && q == '0) |=> (q == {PTR_W{1'b1}})); // R7

endmodule

// File: rtl/stkptr_bus_port.sv
module stkptr_bus_port #(
  parameter int PTR_W = 8
) (
  input  logic             rd_sel,
  input  logic [PTR_W-1:0] q,
  output logic [PTR_W-1:0] bus_out,
  output logic             bus_oe
);

  // Drive only while selected; park the data lines at zero otherwise.
  assign bus_oe  = rd_sel;
  assign bus_out = rd_sel ? q : '0;

endmodule

// File: rtl/stkptr_updown.sv
module stkptr_updown
  import stkptr_pkg::*;
#(
  parameter int PTR_W     = 8,
  parameter bit TOG_CHAIN = 1'b1
) (
  input  logic             clk,
  input  logic             stk_en,
  input  logic             cc_dn,
  input  logic             cc_up,
  input  logic             wr_sel,
  input  logic             rd_sel,
  input  logic [PTR_W-1:0] bus_in,
  output logic [PTR_W-1:0] bus_out,
  output logic             bus_oe,
  output logic [PTR_W-1:0] ptr_addr
);

  sp_op_e           op;
  logic [PTR_W-1:0] ptr_q;

  stkptr_op_decode u_dec (
    .stk_en (stk_en),
    .cc_dn  (cc_dn),
    .cc_up  (cc_up),
    .wr_sel (wr_sel),
    .op     (op)
  );

  stkptr_count_core #(
    .PTR_W     (PTR_W),
    .TOG_CHAIN (TOG_CHAIN)
  ) u_core (
    .clk (clk),
    .op  (op),
    .din (bus_in),
    .q   (ptr_q)
  );

  stkptr_bus_port #(
    .PTR_W (PTR_W)
  ) u_bus (
    .rd_sel  (rd_sel),
    .q       (ptr_q),
    .bus_out (bus_out),
    .bus_oe  (bus_oe)
  );

  assign ptr_addr = ptr_q;

  logic chk_live = 1'b0;
  logic chk_loaded = 1'b0;
  always_ff @(posedge clk) begin
    chk_live <= 1'b1;
    if (wr_sel) chk_loaded <= 1'b1;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!chk_live)
    (wr_sel && stk_en && (cc_dn ^ cc_up)) |=> (ptr_addr == $past(bus_in))); // R6

  AST_CC_NO_STROBE: assert property (@(posedge clk) disable iff (!chk_loaded)
    (!stk_en && !wr_sel) |=> $stable(ptr_addr)); // R4

  AST_BUS_MIRROR: assert property (@(posedge clk) disable iff (!chk_loaded)
    bus_oe |-> (bus_out == ptr_addr)); // R8

  AST_BUS_PARKED: assert property (@(posedge clk) disable iff (!chk_live)
    !rd_sel |-> (!bus_oe && bus_out == '0)); // R8

  AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (!chk_loaded)
    (rd_sel && !wr_sel && !stk_en) |=> $stable(ptr_addr)); // R9

endmodule

// File: tb/stkptr_updown_tb_top.sv
module stkptr_updown_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 16;

  logic         clk = 1'b0;
  logic         stk_en = 1'b0, cc_dn = 1'b0, cc_up = 1'b0;
  logic         wr_sel = 1'b0, rd_sel = 1'b0;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] bus_out, ptr_addr;
  logic         bus_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stkptr_updown #(.PTR_W(W)) dut_i (
    .clk(clk), .stk_en(stk_en), .cc_dn(cc_dn), .cc_up(cc_up),
    .wr_sel(wr_sel), .rd_sel(rd_sel), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .ptr_addr(ptr_addr)
  );

  // Vector: {stk_en, cc_dn, cc_up, wr_sel, rd_sel} din expected_ptr expected_oe
  localparam logic [21:0] VEC [NVEC] = '{
    {5'b00010, 8'h10, 8'h10, 1'b0},
    {5'b10100, 8'h00, 8'h11, 1'b0},
    {5'b10101, 8'h00, 8'h12, 1'b1},
    {5'b11000, 8'h00, 8'h11, 1'b0},
    {5'b01000, 8'h33, 8'h11, 1'b0},
    {5'b00100, 8'h33, 8'h11, 1'b0},
    {5'b11100, 8'h00, 8'h11, 1'b0},
    {5'b10000, 8'h00, 8'h11, 1'b0},
    {5'b10110, 8'h40, 8'h40, 1'b0},
    {5'b11010, 8'h7F, 8'h7F, 1'b0},
    {5'b00010, 8'hFF, 8'hFF, 1'b0},
    {5'b10100, 8'h00, 8'h00, 1'b0},
    {5'b11000, 8'h00, 8'hFF, 1'b0},
    {5'b00001, 8'h00, 8'hFF, 1'b1},
    {5'b00011, 8'h5A, 8'h5A, 1'b1},
    {5'b01101, 8'hA5, 8'h5A, 1'b1}
  };

  function automatic string vec_tag(int k);
    case (k)
      0:  return "R1";
      1:  return "R3";
      2:  return "R8";
      3:  return "R2";
      4, 5: return "R4";
      6, 7: return "R5";
      8, 9: return "R6";
      10: return "R1";
      11, 12: return "R7";
      13: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Inputs change on the falling edge; outputs read a quarter period after the rising edge.
  task automatic cycle(logic se, logic dn, logic up, logic wr, logic rd, logic [W-1:0] d);
    @(negedge clk);
    stk_en = se; cc_dn = dn; cc_up = up; wr_sel = wr; rd_sel = rd; bus_in = d;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] model;
    logic [15:0]  lfsr;
    // Power-up: bus released before any read (R8)
    #(CLK_PERIOD/4);
    check("R8 idle oe", int'(bus_oe), 0);
    check("R8 idle data", int'(bus_out), 0);

    for (int k = 0; k < NVEC; k++) begin
      logic [21:0] v;
      v = VEC[k];
      cycle(v[21], v[20], v[19], v[18], v[17], v[16:9]);
      check(vec_tag(k), int'(ptr_addr), int'(v[8:1]));
      check("R8 oe", int'(bus_oe), int'(v[0]));
      check("R8 data", int'(bus_out), v[0] ? int'(v[8:1]) : 0);
    end

    // Every load value, read back through the bus (R1, R8)
    for (int d = 0; d < 256; d++) begin
      cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, W'(d));
      check("R1 sweep", int'(ptr_addr), d);
      check("R8 sweep", int'(bus_out), d);
    end

    // Full revolution upward then downward (R3, R2, R7)
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hF0);
    model = 8'hF0;
    for (int s = 0; s < 300; s++) begin
      cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
      model = model + 8'd1;
      check("R3 run", int'(ptr_addr), int'(model));
    end
    for (int s = 0; s < 300; s++) begin
      cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      model = model - 8'd1;
      check("R2 run", int'(ptr_addr), int'(model));
    end

    // Mixed pseudo-random controls against a reference model (R2..R9 behaviour)
    lfsr = 16'hACE1;
    for (int s = 0; s < 3000; s++) begin
      logic se, dn, up, wr, rd;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      se = lfsr[0]; dn = lfsr[3]; up = lfsr[5];
      wr = (lfsr[9:7] == 3'b000); rd = lfsr[11];
      cycle(se, dn, up, wr, rd, lfsr[15:8]);
      if (wr)                   model = lfsr[15:8];
      else if (se && dn && !up) model = model - 8'd1;
      else if (se && up && !dn) model = model + 8'd1;
      check("R6 mix ptr", int'(ptr_addr), int'(model));
      check("R8 mix oe", int'(bus_oe), int'(rd));
      check("R8 mix data", int'(bus_out), rd ? int'(model) : 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule